// File: doc/BRIEF.md
# Store Buffer with Memory-Mapped I/O Bypass

This block sits between one CPU's execute stage and a shared memory port. Ordinary stores are taken into a small queue and retired to memory later, so the CPU can move on at once. Loads look into the queue first. A load is answered directly from the queue when the youngest queued store touching its bytes covers all of them. When the queued stores cover only part of its bytes, the load waits until those stores have reached memory. A load that touches no queued byte goes straight to memory and may pass stores that are still queued.

Accesses whose address falls in the memory-mapped I/O window never enter the queue. The block first retires every queued store, then performs the access on the memory port with an I/O flag set, and reports completion only after the device's acknowledge. A full or write-only barrier request completes only when the queue is empty and every queued store has been acknowledged by memory. The queue retires one entry per memory acknowledge, oldest first.

The CPU presents a request and holds it until `cpu_done` pulses. `cpu_stall` is high while a request is held and not yet done.

Top module: `stbuf_top`

## Requirements
- R1: After reset, `mem_req` and `cpu_done` are low, and with `cpu_req` low `cpu_stall` is low.
- R2: A store (`cpu_op` = 1) to a non-I/O address with room in the queue raises `cpu_done` one cycle after it is presented, without waiting for memory. `cpu_done` is a single-cycle pulse.
- R3: The queue holds DEPTH (default 4) stores. A store that finds it full keeps `cpu_stall` high and does not complete until memory has acknowledged the oldest queued entry.
- R4: Queued stores are written to memory in program order, one per `mem_ack`. `mem_req` stays high, with address and write data unchanged, until `mem_ack`.
- R5: A load (`cpu_op` = 0) is served from the queue one cycle after it is presented, with no memory read, when the youngest queued store to the same word that shares any byte with it covers every byte the load enables. It returns that store's data.
- R6: A load that only partly overlaps the youngest overlapping queued store waits until the overlapping stores are in memory. It then returns the program-order value.
- R7: A load sharing no byte with any queued store is read from memory ahead of queued stores to other words that have not yet been written.
- R8: An address `a` is I/O when `(a & IO_MASK) == IO_BASE` (default top four bits all ones). Such a load or store is never queued. It is issued with `mem_io` = 1 only after every earlier store is in memory, and completes only after `mem_ack`.
- R9: Full barrier (`cpu_op` = 2) and write barrier (`cpu_op` = 3) complete only when the queue is empty and all its stores are acknowledged. With the queue already empty, they complete one cycle after being presented.
- R10: Byte lane k of the data buses is bits 8k+7:8k and is enabled by bit k of the byte enable. Read data lanes that are not enabled return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU request valid, held until `cpu_done` |
| cpu_op | input | 2 | 0 load, 1 store, 2 full barrier, 3 write barrier |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Store data |
| cpu_be | input | DW/8 | Byte enables |
| cpu_stall | output | 1 | Request held and not yet complete |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Load data, valid with `cpu_done` |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | Memory write |
| mem_io | output | 1 | Request targets the I/O window |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_be | output | DW/8 | Memory byte enables |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | DW | Memory read data, valid with `mem_ack` |

## Verification
Stores that find room, loads served from the queue, and barriers on an empty queue pass through one register, so the bench requires `cpu_done` on the first falling edge after presenting them and checks that the cycle count is exactly one. Memory-bound results arrive one cycle after the acknowledge, and the acknowledge delay is randomized. For these the bench polls for the done pulse, and for the waiting cases it withholds acknowledges for a fixed window in which any done pulse is an error. Drain order and the drained state at each I/O access are checked inside the bench's memory model at the moment it acknowledges.

// File: rtl/stbuf_pkg.sv
`timescale 1ns/1ps
package stbuf_pkg;
  // CPU operation codes; the two barrier codes share bit 1.
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_FULLB = 2'd2,
    OP_WRB   = 2'd3
  } cpu_op_e;
endpackage

// File: rtl/stbuf_io_dec.sv
`timescale 1ns/1ps
// Flags addresses inside the memory-mapped I/O window.
module stbuf_io_dec #(
  parameter int AW = 32,
  parameter logic [AW-1:0] BASE = 32'hF000_0000,
  parameter logic [AW-1:0] MASK = 32'hF000_0000
) (
  input  logic [AW-1:0] addr,
  output logic          is_io
);
  assign is_io = (addr & MASK) == BASE;
endmodule

// File: rtl/stbuf_fifo.sv
`timescale 1ns/1ps
// Circular queue of pending stores with a youngest-first forwarding lookup.
module stbuf_fifo #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     push,
  input  logic [AW-1:0]            push_addr,
  input  logic [DW-1:0]            push_data,
  input  logic [DW/8-1:0]          push_be,
  input  logic                     pop,
  output logic [AW-1:0]            head_addr,
  output logic [DW-1:0]            head_data,
  output logic [DW/8-1:0]          head_be,
  output logic [$clog2(DEPTH):0]   count,
  output logic                     full,
  output logic                     empty,
  input  logic [AW-1:0]            lk_addr,
  input  logic [DW/8-1:0]          lk_be,
  output logic                     lk_hit,
  output logic                     lk_cover,
  output logic [DW-1:0]            lk_data
);
  localparam int BW = DW / 8;
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  // Storage without reset so it maps onto distributed RAM.
  logic [AW-1:0] a_mem [DEPTH];
  logic [DW-1:0] d_mem [DEPTH];
  logic [BW-1:0] b_mem [DEPTH];

  logic [PW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] idx;

  always_ff @(posedge clk) begin
    if (push) begin
      a_mem[tail_q] <= push_addr;
      d_mem[tail_q] <= push_data;
      b_mem[tail_q] <= push_be;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) tail_q <= tail_q + PW'(1);
      if (pop)  head_q <= head_q + PW'(1);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_addr = a_mem[head_q];
  assign head_data = d_mem[head_q];
  assign head_be   = b_mem[head_q];
  assign count     = cnt_q;
  assign full      = cnt_q == CW'(DEPTH);
  assign empty     = cnt_q == '0;

  // Walk from oldest to youngest; the last overlapping entry wins.
  always_comb begin
    lk_hit   = 1'b0;
    lk_cover = 1'b0;
    lk_data  = '0;
    idx      = head_q;
    for (int i = 0; i < DEPTH; i++) begin
      idx = head_q + PW'(i);
      if ((CW'(i) < cnt_q) && (a_mem[idx] == lk_addr) &&
          ((b_mem[idx] & lk_be) != '0)) begin
        lk_hit   = 1'b1;
        lk_cover = (lk_be & ~b_mem[idx]) == '0;
        lk_data  = d_mem[idx];
      end
    end
  end
endmodule

// File: rtl/stbuf_port.sv
`timescale 1ns/1ps
// Single outstanding request on the memory side, held until acknowledged.
module stbuf_port #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            iss_valid,
  input  logic            iss_we,
  input  logic            iss_io,
  input  logic            iss_drain,
  input  logic [AW-1:0]   iss_addr,
  input  logic [DW-1:0]   iss_data,
  input  logic [DW/8-1:0] iss_be,
  output logic            busy,
  output logic            ack_drain,
  output logic            ack_cpu,
  output logic            mem_req,
  output logic            mem_we,
  output logic            mem_io,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic [DW/8-1:0] mem_be,
  input  logic            mem_ack
);
  logic drain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_io    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_be    <= '0;
      drain_q   <= 1'b0;
    end else if (!mem_req) begin
      if (iss_valid) begin
        mem_req   <= 1'b1;
        mem_we    <= iss_we;
        mem_io    <= iss_io;
        mem_addr  <= iss_addr;
        mem_wdata <= iss_data;
        mem_be    <= iss_be;
        drain_q   <= iss_drain;
      end
    end else if (mem_ack) begin
      mem_req <= 1'b0;
    end
  end

  assign busy      = mem_req;
  assign ack_drain = mem_req & mem_ack & drain_q;
  assign ack_cpu   = mem_req & mem_ack & ~drain_q;
endmodule

// File: rtl/stbuf_top.sv
`timescale 1ns/1ps
// Per-CPU store queue with forwarding, barrier waits and an I/O bypass path.
module stbuf_top
  import stbuf_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  parameter logic [AW-1:0] IO_BASE = 32'hF000_0000,
  parameter logic [AW-1:0] IO_MASK = 32'hF000_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cpu_req,
  input  logic [1:0]      cpu_op,
  input  logic [AW-1:0]   cpu_addr,
  input  logic [DW-1:0]   cpu_wdata,
  input  logic [DW/8-1:0] cpu_be,
  output logic            cpu_stall,
  output logic            cpu_done,
  output logic [DW-1:0]   cpu_rdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic            mem_io,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic [DW/8-1:0] mem_be,
  input  logic            mem_ack,
  input  logic [DW-1:0]   mem_rdata
);
  localparam int BW = DW / 8;
  localparam int CW = $clog2(DEPTH) + 1;

  function automatic logic [DW-1:0] lane_mask(input logic [BW-1:0] be);
    logic [DW-1:0] m;
    for (int b = 0; b < BW; b++) m[8*b +: 8] = {8{be[b]}};
    return m;
  endfunction

  cpu_op_e       op;
  logic          io_hit;
  logic [CW-1:0] buf_cnt;
  logic          full, empty;
  logic          lk_hit, lk_cover;
  logic [DW-1:0] lk_data;
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_data;
  logic [BW-1:0] head_be;
  logic          busy, ack_drain, ack_cpu;
  logic          act, is_ld, is_st, is_bar;
  logic          bar_fin, st_fin, fwd_fin, cpu_iss, drn_iss, push;
  logic          iss_valid, iss_we, iss_io;
  logic [AW-1:0] iss_addr;
  logic [DW-1:0] iss_data;
  logic [BW-1:0] iss_be;
  logic          done_q, wait_q;
  logic [DW-1:0] rdata_q;

  stbuf_io_dec #(.AW(AW), .BASE(IO_BASE), .MASK(IO_MASK)) u_dec (
    .addr  (cpu_addr),
    .is_io (io_hit)
  );

  stbuf_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_addr (cpu_addr),
    .push_data (cpu_wdata),
    .push_be   (cpu_be),
    .pop       (ack_drain),
    .head_addr (head_addr),
    .head_data (head_data),
    .head_be   (head_be),
    .count     (buf_cnt),
    .full      (full),
    .empty     (empty),
    .lk_addr   (cpu_addr),
    .lk_be     (cpu_be),
    .lk_hit    (lk_hit),
    .lk_cover  (lk_cover),
    .lk_data   (lk_data)
  );

  // Request decode; nothing is acted on in the done cycle or while the
  // CPU's own memory access is outstanding.
  always_comb begin
    op     = cpu_op_e'(cpu_op);
    act    = cpu_req & ~done_q & ~wait_q;
    is_ld  = act & (op == OP_LOAD);
    is_st  = act & (op == OP_STORE);
    is_bar = act & ((op == OP_FULLB) | (op == OP_WRB));

    bar_fin = is_bar & empty;
    st_fin  = is_st & ~io_hit & ~full;
    fwd_fin = is_ld & ~io_hit & lk_hit & lk_cover;
    cpu_iss = ~busy & ((is_ld & ~io_hit & ~lk_hit) |
                       ((is_ld | is_st) & io_hit & empty));
    drn_iss = ~busy & ~cpu_iss & ~empty;
    push    = st_fin;

    iss_valid = cpu_iss | drn_iss;
    if (cpu_iss) begin
      iss_we   = is_st;
      iss_io   = io_hit;
      iss_addr = cpu_addr;
      iss_data = cpu_wdata;
      iss_be   = cpu_be;
    end else begin
      iss_we   = 1'b1;
      iss_io   = 1'b0;
      iss_addr = head_addr;
      iss_data = head_data;
      iss_be   = head_be;
    end
  end

  stbuf_port #(.AW(AW), .DW(DW)) u_port (
    .clk       (clk),
    .rst       (rst),
    .iss_valid (iss_valid),
    .iss_we    (iss_we),
    .iss_io    (iss_io),
    .iss_drain (drn_iss),
    .iss_addr  (iss_addr),
    .iss_data  (iss_data),
    .iss_be    (iss_be),
    .busy      (busy),
    .ack_drain (ack_drain),
    .ack_cpu   (ack_cpu),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_io    (mem_io),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_be    (mem_be),
    .mem_ack   (mem_ack)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q  <= 1'b0;
      wait_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= bar_fin | st_fin | fwd_fin | ack_cpu;
      if (cpu_iss)      wait_q <= 1'b1;
      else if (ack_cpu) wait_q <= 1'b0;
      if (fwd_fin)      rdata_q <= lk_data & lane_mask(cpu_be);
      else if (ack_cpu) rdata_q <= mem_we ? '0 : (mem_rdata & lane_mask(mem_be));
    end
  end

  assign cpu_done  = done_q;
  assign cpu_rdata = rdata_q;
  assign cpu_stall = cpu_req & ~done_q;
endmodule

// File: rtl/stbuf_chk.sv
`timescale 1ns/1ps
// Protocol and ordering properties of the store queue.
module stbuf_chk #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   mem_req,
  input logic                   mem_ack,
  input logic                   mem_io,
  input logic [AW-1:0]          mem_addr,
  input logic [DW-1:0]          mem_wdata,
  input logic                   cpu_done,
  input logic [1:0]             cpu_op,
  input logic [$clog2(DEPTH):0] cnt,
  input logic                   push,
  input logic                   full
);
  localparam int CW = $clog2(DEPTH) + 1;

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  assert_push_room_R3: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

  assert_io_drained_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_io) |-> (cnt == '0));

  assert_barrier_empty_R9: assert property (@(posedge clk) disable iff (rst)
    (cpu_done && cpu_op[1]) |-> (cnt == '0));

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done);
endmodule

bind stbuf_top stbuf_chk #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_io    (mem_io),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .cpu_done  (cpu_done),
  .cpu_op    (cpu_op),
  .cnt       (buf_cnt),
  .push      (push),
  .full      (full)
);

// File: tb/sim_stbuf_top.sv
`timescale 1ns/1ps
module sim_stbuf_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0;
  logic [1:0]  cpu_op = 2'd0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [3:0]  cpu_be = '0;
  logic        cpu_stall, cpu_done;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we, mem_io;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  stbuf_top u0 (.*);

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0, errors = 0, total = 0, lat = 0, wptr = 0;
  bit ack_en = 1'b1;
  logic [31:0] mem_arr [16];
  logic [31:0] ref_arr [16];
  logic [31:0] io_regs [4];
  logic [31:0] wlog [64];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lanes(input logic [3:0] be);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{be[b]}};
    return m;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
    return (o & ~lanes(be)) | (n & lanes(be));
  endfunction

  function automatic bit is_io(input logic [31:0] a);
    return (a & 32'hF000_0000) == 32'hF000_0000;
  endfunction

  // Memory and device model; acknowledges on falling edges.
  always @(negedge clk) begin
    if (rst) begin
      mem_ack = 1'b0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req && ack_en) begin
      if (lat > 0) lat--;
      else begin
        int diff;
        chk(mem_io == is_io(mem_addr), "R8 io flag", {31'd0, mem_io}, {31'd0, is_io(mem_addr)});
        if (mem_io) begin
          diff = 0;
          for (int i = 0; i < 16; i++) if (mem_arr[i] != ref_arr[i]) diff++;
          chk(diff == 0, "R8 stores drained before io", 32'(diff), 32'd0);
          if (mem_we) io_regs[mem_addr[1:0]] = merge(io_regs[mem_addr[1:0]], mem_wdata, mem_be);
          else        mem_rdata = io_regs[mem_addr[1:0]];
        end else if (mem_we) begin
          mem_arr[mem_addr[3:0]] = merge(mem_arr[mem_addr[3:0]], mem_wdata, mem_be);
          if (wptr < 64) wlog[wptr] = mem_addr;
          wptr++;
        end else begin
          mem_rdata = mem_arr[mem_addr[3:0]];
        end
        mem_ack = 1'b1;
        lat = $urandom_range(0, 2);
      end
    end
  end

  always @(posedge clk) begin
    total++;
    if (total == 190000) begin
      chk(1'b0, "watchdog", 32'(total), 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic do_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] d,
                       input logic [3:0] be, input int gate,
                       output int cyc, output logic [31:0] rd, output bit early);
    cpu_op = op; cpu_addr = a; cpu_wdata = d; cpu_be = be; cpu_req = 1'b1;
    cyc = 0; early = 1'b0;
    if (gate > 0) begin
      ack_en = 1'b0;
      for (int k = 0; k < gate; k++) begin
        @(negedge clk); cyc++;
        if (cpu_done) early = 1'b1;
        if (!cpu_done && !cpu_stall) chk(1'b0, "R3 stall while held", 32'd0, 32'd1);
      end
      ack_en = 1'b1;
    end
    while (!early && !cpu_done && cyc < 2000) begin @(negedge clk); cyc++; end
    if (!early && !cpu_done) chk(1'b0, "op timeout", 32'(cyc), 32'd0);
    rd = cpu_rdata;
    cpu_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic st(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be,
                    input int gate, output int cyc, output bit early);
    logic [31:0] rd;
    do_op(2'd1, a, d, be, gate, cyc, rd, early);
    if (!is_io(a)) ref_arr[a[3:0]] = merge(ref_arr[a[3:0]], d, be);
  endtask

  task automatic ld(input logic [31:0] a, input logic [3:0] be, input int gate, input string tag,
                    output int cyc, output bit early);
    logic [31:0] rd, exp;
    do_op(2'd0, a, 32'd0, be, gate, cyc, rd, early);
    exp = (is_io(a) ? io_regs[a[1:0]] : ref_arr[a[3:0]]) & lanes(be);
    chk(rd == exp, tag, rd, exp);
  endtask

  task automatic bar(input logic [1:0] op, input int gate, output int cyc, output bit early);
    logic [31:0] rd;
    int diff;
    do_op(op, 32'd0, 32'd0, 4'hF, gate, cyc, rd, early);
    diff = 0;
    for (int i = 0; i < 16; i++) if (mem_arr[i] != ref_arr[i]) diff++;
    chk(diff == 0, "R9 memory complete after barrier", 32'(diff), 32'd0);
  endtask

  initial begin
    int cyc;
    bit early;
    logic [31:0] d;
    logic [31:0] old12;
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) begin mem_arr[i] = $urandom; ref_arr[i] = mem_arr[i]; end
    for (int i = 0; i < 4; i++) io_regs[i] = $urandom;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle after reset
    chk(mem_req == 1'b0, "R1 mem_req idle", {31'd0, mem_req}, 32'd0);
    chk(cpu_done == 1'b0, "R1 done idle", {31'd0, cpu_done}, 32'd0);
    chk(cpu_stall == 1'b0, "R1 stall idle", {31'd0, cpu_stall}, 32'd0);

    // R2/R3/R4/R5: fill the queue with memory acknowledges withheld
    ack_en = 1'b0; wptr = 0;
    st(32'd1, 32'hAAAA_0001, 4'hF, 0, cyc, early);
    chk(cyc == 1, "R2 store done in one cycle", 32'(cyc), 32'd1);
    st(32'd3, 32'h3333_3333, 4'hF, 0, cyc, early);
    st(32'd3, 32'h0000_5A5A, 4'b0011, 0, cyc, early);
    st(32'd5, 32'h5555_0005, 4'hF, 0, cyc, early);
    chk(cyc == 1, "R2 fourth store one cycle", 32'(cyc), 32'd1);
    chk(mem_arr[1] != ref_arr[1], "R2 store not yet in memory", mem_arr[1], ~ref_arr[1]);
    chk(mem_req && mem_we && mem_addr == 32'd1, "R4 oldest entry on port", mem_addr, 32'd1);
    chk(mem_wdata == 32'hAAAA_0001, "R4 oldest data on port", mem_wdata, 32'hAAAA_0001);
    ld(32'd3, 4'b0011, 0, "R5 forward youngest", cyc, early);
    chk(cyc == 1, "R5 forward one cycle", 32'(cyc), 32'd1);
    ld(32'd3, 4'b1100, 0, "R5 forward older covering entry", cyc, early);
    chk(cyc == 1, "R5 forward older one cycle", 32'(cyc), 32'd1);
    st(32'd6, 32'h6666_0006, 4'hF, 6, cyc, early);
    chk(!early, "R3 full queue stalls store", {31'd0, early}, 32'd0);
    bar(2'd2, 0, cyc, early);
    chk(wptr == 5, "R4 write count", 32'(wptr), 32'd5);
    chk(wlog[0] == 1 && wlog[1] == 3 && wlog[2] == 3 && wlog[3] == 5 && wlog[4] == 6,
        "R4 drain order", {wlog[0][7:0], wlog[1][7:0], wlog[3][7:0], wlog[4][7:0]}, 32'h0103_0506);

    // R6: partial overlap waits for the drain
    ack_en = 1'b0;
    st(32'd7, ~ref_arr[7], 4'hF, 0, cyc, early);
    st(32'd7, 32'h0000_00C3, 4'b0001, 0, cyc, early);
    ld(32'd7, 4'hF, 6, "R6 partial overlap value", cyc, early);
    chk(!early, "R6 partial overlap waits", {31'd0, early}, 32'd0);
    chk(mem_arr[7] == ref_arr[7], "R6 stores drained first", mem_arr[7], ref_arr[7]);

    // R8: io access waits for drain and for its acknowledge
    ack_en = 1'b0;
    st(32'd8, ~ref_arr[8], 4'hF, 0, cyc, early);
    d = $urandom;
    st(32'hF000_0001, d, 4'hF, 6, cyc, early);
    chk(!early, "R8 io store synchronous", {31'd0, early}, 32'd0);
    chk(io_regs[1] == d, "R8 io store reached device", io_regs[1], d);
    ld(32'hF000_0001, 4'b0110, 0, "R8 R10 io load masked lanes", cyc, early);

    // R9: barriers
    ack_en = 1'b0;
    st(32'd9, ~ref_arr[9], 4'hF, 0, cyc, early);
    bar(2'd2, 5, cyc, early);
    chk(!early, "R9 full barrier waits", {31'd0, early}, 32'd0);
    bar(2'd3, 0, cyc, early);
    chk(cyc == 1, "R9 empty barrier one cycle", 32'(cyc), 32'd1);
    ack_en = 1'b0;
    st(32'd10, ~ref_arr[10], 4'hF, 0, cyc, early);
    bar(2'd3, 4, cyc, early);
    chk(!early, "R9 write barrier waits", {31'd0, early}, 32'd0);

    // R7: non-overlapping load passes queued stores
    ack_en = 1'b0;
    old12 = mem_arr[12];
    st(32'd11, ~ref_arr[11], 4'hF, 0, cyc, early);
    st(32'd12, ~ref_arr[12], 4'hF, 0, cyc, early);
    st(32'd13, ~ref_arr[13], 4'hF, 0, cyc, early);
    ld(32'd14, 4'hF, 2, "R7 bypass load value", cyc, early);
    chk(mem_arr[12] == old12, "R7 load ahead of queued store", mem_arr[12], old12);
    bar(2'd2, 0, cyc, early);

    // Random mix, R10 lanes exercised throughout
    ack_en = 1'b1;
    for (int n = 0; n < 600; n++) begin
      int r;
      logic [31:0] a;
      logic [3:0] be;
      r  = $urandom_range(0, 99);
      a  = 32'($urandom_range(0, 15));
      be = 4'($urandom_range(1, 15));
      if (r < 40)      st(a, $urandom, be, 0, cyc, early);
      else if (r < 75) ld(a, be, 0, "R5 R6 R7 R10 random load", cyc, early);
      else if (r < 82) st(32'hF000_0000 | 32'($urandom_range(0, 3)), $urandom, be, 0, cyc, early);
      else if (r < 89) ld(32'hF000_0000 | 32'($urandom_range(0, 3)), be, 0, "R8 R10 random io load", cyc, early);
      else if (r < 95) bar(2'd2, 0, cyc, early);
      else             bar(2'd3, 0, cyc, early);
    end
    bar(2'd2, 0, cyc, early);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule